// File: doc/BRIEF.md
# Timer Compare Match Unit

The block watches a free-running timer value supplied from outside and checks it, on every clock cycle, against a compare register that software loads through a write strobe. When the timer first reaches the compare value, the block records an event in a sticky flag and, depending on a 4-bit mode code, drives its output pin high, drives it low, or leaves the pin alone. One mode also emits a single-cycle request asking the external timer to restart from zero.

The core is a small state machine. `ST_OFF` is the idle state taken for code 0000 and for every unlisted code. `ST_ARM_HI` (pin low, waiting) moves to `ST_HELD_HI` (pin high) on a match in code 1000; `ST_ARM_LO` (pin high, waiting) moves to `ST_HELD_LO` (pin low) on a match in code 1001. `ST_EVENT` serves the flag-only codes 0010, 1010 and 1011 and has no transition of its own. Any change of the mode input is an entry transition: the machine jumps straight to the entry state of the new code (`ST_ARM_HI`, `ST_ARM_LO`, `ST_EVENT` or `ST_OFF`). All match effects (flag, pin, timer-reset request) appear together on the clock edge that ends the cycle in which the timer first equals the compare value.

Top module: `tcmp_unit`

## Requirements
- R1: After reset the pin, the flag, the interrupt request and the timer-reset request are all 0, and the compare register holds 0.
- R2: A compare register write is used for matching from the cycle after the write strobe; in the strobe cycle the old value is still compared.
- R3: A match is taken only in the first cycle in which timer and compare register are equal; a timer that stays on the compare value gives no further match.
- R4: Code 1000 (4'h8): on entry the pin is driven to 0; a match drives it to 1, and it stays 1 for as long as the code is held.
- R5: Code 1001 (4'h9): on entry the pin is driven to 1; a match drives it to 0, and it stays 0 for as long as the code is held.
- R6: The flag sets on the same clock edge that applies the pin action, one edge after the cycle in which the values first agree.
- R7: Codes 0010 (4'h2) and 1010 (4'hA) set the flag on a match and leave the pin at its current level, also on entry.
- R8: Code 1011 (4'hB) sets the flag on a match and raises the timer-reset request for exactly one cycle, aligned with the flag; the pin is left alone.
- R9: Code 0000 and any code other than 2, 8, 9, A and B disable the block: pin and flag are 0 from the next edge and no match is taken.
- R10: In the cycle in which the mode input differs from the previous cycle no match is taken, and a change between two enabled codes keeps the flag.
- R11: In an enabled code the flag clears only through the clear strobe; a match in the same cycle as the strobe wins and the flag stays 1.
- R12: The interrupt request is high exactly when the flag and the interrupt enable are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_val | input | 16 | Current timer count |
| cmp_wr_en | input | 1 | Load strobe for the compare register |
| cmp_wr_data | input | 16 | Compare value to load |
| mode | input | 4 | Mode code |
| flag_clr | input | 1 | Clear strobe for the event flag |
| irq_en | input | 1 | Interrupt enable |
| pin_out | output | 1 | Compare output pin |
| flag | output | 1 | Sticky event flag |
| irq | output | 1 | Interrupt request |
| tmr_rst_req | output | 1 | One-cycle request to restart the timer |

## Verification
The properties assume the mode input is held at 0000 while reset is active and changes only between clock edges, and that the timer value is a plain registered count, so an equality cannot rise in two consecutive cycles without the timer leaving the compare value between them. The stimulus changes every input only at the falling clock edge, keeps the mode at 0000 through reset, and moves the timer off the compare value before each intended new match, so a repeated equality is only ever presented as a deliberate pause. Entry transitions are exercised with the timer already on the compare value to show that a rising equality in the entry cycle is dropped.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] MODE_OFF       = 4'h0;
    localparam logic [MODE_W-1:0] MODE_CMP_FLAG  = 4'h2;
    localparam logic [MODE_W-1:0] MODE_DRIVE_HI  = 4'h8;
    localparam logic [MODE_W-1:0] MODE_DRIVE_LO  = 4'h9;
    localparam logic [MODE_W-1:0] MODE_FLAG      = 4'hA;
    localparam logic [MODE_W-1:0] MODE_RESET_REQ = 4'hB;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_ARM_HI,
        ST_HELD_HI,
        ST_ARM_LO,
        ST_HELD_LO,
        ST_EVENT
    } fsm_state_t;

    // State the machine takes when a mode code is first applied.
    function automatic fsm_state_t entry_state(input logic [MODE_W-1:0] code);
        fsm_state_t st;
        case (code)
            MODE_DRIVE_HI:  st = ST_ARM_HI;
            MODE_DRIVE_LO:  st = ST_ARM_LO;
            MODE_CMP_FLAG,
            MODE_FLAG,
            MODE_RESET_REQ: st = ST_EVENT;
            default:        st = ST_OFF;
        endcase
        return st;
    endfunction

endpackage

// File: rtl/tcmp_match_detect.sv
module tcmp_match_detect #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tmr_val,
    input  logic          cmp_wr_en,
    input  logic [TW-1:0] cmp_wr_data,
    output logic          eq_rise
);

    logic [TW-1:0] cmp_q;
    logic [TW-1:0] bit_eq;
    logic          eq_now;
    logic          eq_q;

    // Compare register: a write lands at the edge, so it is used next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (cmp_wr_en) begin
            cmp_q <= cmp_wr_data;
        end
    end

    // Per-bit equality, reduced below.
    for (genvar i = 0; i < TW; i++) begin : g_bit_eq
        assign bit_eq[i] = ~(tmr_val[i] ^ cmp_q[i]);
    end

    assign eq_now = &bit_eq;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eq_q <= 1'b0;
        end else begin
            eq_q <= eq_now;
        end
    end

    // Only the first cycle of equality counts.
    assign eq_rise = eq_now & ~eq_q;

endmodule

// File: rtl/tcmp_mode_fsm.sv
module tcmp_mode_fsm
    import tcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              eq_rise,
    output logic              match,
    output logic              go_off,
    output logic              reset_code,
    output logic              pin_out
);

    fsm_state_t        state_q;
    fsm_state_t        state_d;
    logic [MODE_W-1:0] mode_q;
    logic              mode_steady;
    logic              pin_q;

    assign mode_steady = (mode == mode_q);
    assign match       = eq_rise && mode_steady && (state_q != ST_OFF);
    assign go_off      = (state_d == ST_OFF);
    assign reset_code  = (mode_q == MODE_RESET_REQ);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_OFF;
        end else begin
            mode_q <= mode;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (!mode_steady) begin
            state_d = entry_state(mode);
        end else begin
            unique case (state_q)
                ST_OFF:     state_d = ST_OFF;
                ST_ARM_HI:  state_d = match ? ST_HELD_HI : ST_ARM_HI;
                ST_HELD_HI: state_d = ST_HELD_HI;
                ST_ARM_LO:  state_d = match ? ST_HELD_LO : ST_ARM_LO;
                ST_HELD_LO: state_d = ST_HELD_LO;
                ST_EVENT:   state_d = ST_EVENT;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: pin level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else if (!mode_steady) begin
            unique case (state_d)
                ST_ARM_HI:  pin_q <= 1'b0;
                ST_ARM_LO:  pin_q <= 1'b1;
                ST_EVENT:   pin_q <= pin_q;
                ST_OFF:     pin_q <= 1'b0;
                ST_HELD_HI: pin_q <= 1'b1;
                ST_HELD_LO: pin_q <= 1'b0;
            endcase
        end else begin
            unique case (state_q)
                ST_OFF:     pin_q <= 1'b0;
                ST_ARM_HI:  pin_q <= match ? 1'b1 : pin_q;
                ST_ARM_LO:  pin_q <= match ? 1'b0 : pin_q;
                ST_HELD_HI: pin_q <= 1'b1;
                ST_HELD_LO: pin_q <= 1'b0;
                ST_EVENT:   pin_q <= pin_q;
            endcase
        end
    end

    assign pin_out = pin_q;

endmodule

// File: rtl/tcmp_flag_irq.sv
module tcmp_flag_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic go_off,
    input  logic reset_code,
    input  logic flag_clr,
    input  logic irq_en,
    output logic flag,
    output logic irq,
    output logic tmr_rst_req
);

    logic flag_q;
    logic rst_req_q;

    // Priority: disable, then match, then software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (go_off) begin
            flag_q <= 1'b0;
        end else if (match) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= match && reset_code;
        end
    end

    assign flag        = flag_q;
    assign irq         = flag_q & irq_en;
    assign tmr_rst_req = rst_req_q;

endmodule

// File: rtl/tcmp_unit.sv
module tcmp_unit
    import tcmp_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TW-1:0]     tmr_val,
    input  logic              cmp_wr_en,
    input  logic [TW-1:0]     cmp_wr_data,
    input  logic [MODE_W-1:0] mode,
    input  logic              flag_clr,
    input  logic              irq_en,
    output logic              pin_out,
    output logic              flag,
    output logic              irq,
    output logic              tmr_rst_req
);

    logic eq_rise;
    logic match;
    logic go_off;
    logic reset_code;

    tcmp_match_detect #(
        .TW(TW)
    ) match_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tmr_val     (tmr_val),
        .cmp_wr_en   (cmp_wr_en),
        .cmp_wr_data (cmp_wr_data),
        .eq_rise     (eq_rise)
    );

    tcmp_mode_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .eq_rise    (eq_rise),
        .match      (match),
        .go_off     (go_off),
        .reset_code (reset_code),
        .pin_out    (pin_out)
    );

    tcmp_flag_irq flag_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .match       (match),
        .go_off      (go_off),
        .reset_code  (reset_code),
        .flag_clr    (flag_clr),
        .irq_en      (irq_en),
        .flag        (flag),
        .irq         (irq),
        .tmr_rst_req (tmr_rst_req)
    );

endmodule

// File: rtl/tcmp_checker.sv
module tcmp_checker #(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [TW-1:0] tmr_val,
    input logic [3:0]    mode,
    input logic          flag_clr,
    input logic          irq_en,
    input logic          pin_out,
    input logic          flag,
    input logic          irq,
    input logic          tmr_rst_req
);

    logic mode_on;
    assign mode_on = (mode == 4'h2) || (mode == 4'h8) || (mode == 4'h9) ||
                     (mode == 4'hA) || (mode == 4'hB);

    // R12: no request without a pending flag
    p_irq_needs_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && irq_en));

    // R8: the timer-reset request is a single-cycle pulse
    p_rst_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_rst_req |=> !tmr_rst_req);

    // R8: the request comes with the flag while the restart code was applied
    p_rst_req_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_rst_req |-> (flag && $past(mode) == 4'hB));

    // R9: a disabled code clears pin and flag at the next edge
    p_off_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'h0) |=> (!pin_out && !flag));

    // R11: without a clear strobe an enabled code keeps the flag
    p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr && mode_on) |=> flag);

    // R4: once driven high under a held code 1000 the pin stays high
    p_pin_held_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'h8 && $past(mode) == 4'h8 && pin_out) |=> pin_out);

    // R5: once driven low under a held code 1001 the pin stays low
    p_pin_held_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'h9 && $past(mode) == 4'h9 && !pin_out) |=> !pin_out);

endmodule

bind tcmp_unit tcmp_checker #(
    .TW(TW)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tmr_val     (tmr_val),
    .mode        (mode),
    .flag_clr    (flag_clr),
    .irq_en      (irq_en),
    .pin_out     (pin_out),
    .flag        (flag),
    .irq         (irq),
    .tmr_rst_req (tmr_rst_req)
);

// File: tb/tcmp_unit_tb_top.sv
module tcmp_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TW         = 16;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic  pin;
        logic  flg;
        logic  irq;
        logic  rst;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] tmr_val = '0;
    logic          cmp_wr_en = 1'b0;
    logic [TW-1:0] cmp_wr_data = '0;
    logic [3:0]    mode = 4'h0;
    logic          flag_clr = 1'b0;
    logic          irq_en = 1'b0;
    logic          pin_out;
    logic          flag;
    logic          irq;
    logic          tmr_rst_req;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];

    // Reference state built from the requirements.
    logic [TW-1:0] m_cmp = '0;
    logic          m_eqprev = 1'b0;
    logic [3:0]    m_modeq = 4'h0;
    logic          m_pin = 1'b0;
    logic          m_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcmp_unit #(.TW(TW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tmr_val     (tmr_val),
        .cmp_wr_en   (cmp_wr_en),
        .cmp_wr_data (cmp_wr_data),
        .mode        (mode),
        .flag_clr    (flag_clr),
        .irq_en      (irq_en),
        .pin_out     (pin_out),
        .flag        (flag),
        .irq         (irq),
        .tmr_rst_req (tmr_rst_req)
    );

    function automatic bit code_on(input logic [3:0] c);
        return (c == 4'h2) || (c == 4'h8) || (c == 4'h9) || (c == 4'hA) || (c == 4'hB);
    endfunction

    task automatic compare(input exp_t e);
        checks++;
        if (pin_out !== e.pin || flag !== e.flg || irq !== e.irq || tmr_rst_req !== e.rst) begin
            failures++;
            $display("FAIL %s: pin/flag/irq/rst actual=%b%b%b%b expected=%b%b%b%b",
                     e.tag, pin_out, flag, irq, tmr_rst_req, e.pin, e.flg, e.irq, e.rst);
        end
    endtask

    // Driver: applies one cycle of stimulus and pushes the expected result.
    task automatic step(input logic [TW-1:0] t, input bit w, input logic [TW-1:0] d,
                        input logic [3:0] m, input bit c, input bit ie, input string tag);
        bit   eq, steady, hit;
        exp_t e;
        @(negedge clk);
        tmr_val = t; cmp_wr_en = w; cmp_wr_data = d;
        mode = m; flag_clr = c; irq_en = ie;
        eq     = (t == m_cmp);
        steady = (m == m_modeq);
        hit    = eq && !m_eqprev && steady && code_on(m);
        if (!code_on(m)) begin
            m_pin  = 1'b0;
            m_flag = 1'b0;
        end else begin
            if (!steady) begin
                if (m == 4'h8) m_pin = 1'b0;
                if (m == 4'h9) m_pin = 1'b1;
            end else if (hit) begin
                if (m == 4'h8) m_pin = 1'b1;
                if (m == 4'h9) m_pin = 1'b0;
            end
            if (hit) m_flag = 1'b1;
            else if (c) m_flag = 1'b0;
        end
        m_eqprev = eq;
        m_modeq  = m;
        if (w) m_cmp = d;
        e.pin = m_pin;
        e.flg = m_flag;
        e.irq = m_flag && ie;
        e.rst = hit && (m == 4'hB);
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: samples a quarter period after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) compare(exp_q.pop_front());
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        exp_t r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        r.pin = 1'b0; r.flg = 1'b0; r.irq = 1'b0; r.rst = 1'b0; r.tag = "R1";
        compare(r);

        // R9: disabled, equality is ignored
        step(16'd0,   1, 16'd100, 4'h0, 0, 1, "R9");
        step(16'd50,  0, 16'd0,   4'h0, 0, 1, "R9");
        step(16'd100, 0, 16'd0,   4'h0, 0, 1, "R9");
        // R4 / R6: drive-high code
        step(16'd50,  0, 16'd0,   4'h8, 0, 1, "R4");
        step(16'd99,  0, 16'd0,   4'h8, 0, 1, "R4");
        step(16'd100, 0, 16'd0,   4'h8, 0, 1, "R6");
        // R3: paused timer, clear in between
        step(16'd100, 0, 16'd0,   4'h8, 0, 1, "R3");
        step(16'd100, 0, 16'd0,   4'h8, 1, 1, "R11");
        step(16'd100, 0, 16'd0,   4'h8, 0, 1, "R3");
        step(16'd101, 0, 16'd0,   4'h8, 0, 1, "R4");
        step(16'd100, 0, 16'd0,   4'h8, 0, 1, "R4");
        // R5 / R10: drive-low code, flag kept across the change
        step(16'd5,   0, 16'd0,   4'h9, 0, 1, "R10");
        step(16'd5,   0, 16'd0,   4'h9, 1, 1, "R11");
        step(16'd100, 0, 16'd0,   4'h9, 0, 1, "R5");
        step(16'd7,   0, 16'd0,   4'h9, 1, 1, "R5");
        // R10: equality rising in the entry cycle is dropped
        step(16'd100, 0, 16'd0,   4'h8, 0, 1, "R10");
        step(16'd100, 0, 16'd0,   4'h8, 0, 1, "R3");
        // R2: write and equal value in the same cycle
        step(16'd300, 1, 16'd300, 4'h8, 0, 1, "R2");
        step(16'd300, 0, 16'd0,   4'h8, 0, 1, "R2");
        step(16'd0,   0, 16'd0,   4'h8, 1, 1, "R11");
        // R7: flag-only codes leave the pin
        step(16'd0,   0, 16'd0,   4'h2, 0, 1, "R7");
        step(16'd300, 0, 16'd0,   4'h2, 0, 1, "R7");
        step(16'd1,   0, 16'd0,   4'h2, 1, 1, "R7");
        step(16'd1,   0, 16'd0,   4'hA, 0, 1, "R7");
        step(16'd300, 0, 16'd0,   4'hA, 0, 1, "R7");
        step(16'd2,   0, 16'd0,   4'hA, 1, 1, "R7");
        // R8: timer-reset request
        step(16'd2,   0, 16'd0,   4'hB, 0, 1, "R8");
        step(16'd300, 0, 16'd0,   4'hB, 0, 1, "R8");
        step(16'd0,   0, 16'd0,   4'hB, 0, 1, "R8");
        // R11: match beats a clear in the same cycle
        step(16'd300, 0, 16'd0,   4'hB, 1, 1, "R11");
        step(16'd0,   0, 16'd0,   4'hB, 1, 1, "R11");
        // R12: interrupt gating
        step(16'd300, 0, 16'd0,   4'hB, 0, 0, "R12");
        step(16'd5,   0, 16'd0,   4'hB, 0, 1, "R12");
        step(16'd5,   0, 16'd0,   4'hB, 0, 0, "R12");
        // R9: unlisted code and off
        step(16'd5,   0, 16'd0,   4'h5, 0, 1, "R9");
        step(16'd300, 0, 16'd0,   4'h5, 0, 1, "R9");
        step(16'd5,   0, 16'd0,   4'h0, 0, 1, "R9");
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/2);
        finish_run();
    end

endmodule